// File: doc/BRIEF.md
# Windowed Threshold Interrupt Controller

This block sits beside a multi-channel light converter and decides when the host should be interrupted. Every time the converter presents a fresh set of results, one channel is picked by a source select and compared against a programmable low/high window. A persistence filter counts consecutive out-of-window results before it lets an interrupt through, so brief glitches in intensity do not disturb the host.

The interrupt line is active low and stays asserted until it is cleared. Four modes are offered: output disabled, a level mode cleared by a host clear command, an alert mode cleared by a won alert-response cycle, and a forced mode in which a configuration write raises the interrupt at once and which then behaves like the alert mode. An optional stop-on-interrupt setting tells the converter to halt integration when the interrupt rises. The halt is released only after the converter enable has been dropped while the interrupt is clear.

The bus interface and the converter itself are outside the block. It sees the register fields as plain inputs, plus strobes for a configuration write, a clear command and a won alert response.

Top module: `win_irq_ctrl`

## Requirements
- R1: After a synchronous reset `irq_n` is 1 and `integ_stop` is 0.
- R2: `src_sel` value k picks the channel held in `res_bus[k*DATA_W +: DATA_W]`. Only that channel is compared, and the other channels have no effect.
- R3: A result is out of window when it is below `thr_lo` or above `thr_hi`. A value equal to either threshold is in window and never raises the interrupt, unless the persistence code is 000.
- R4: With `mode` = 00, `irq_n` is 1 from the cycle after the edge that samples that mode. A pending interrupt is discarded, and results sampled in this mode leave nothing pending.
- R5: With `mode` = 01 (level), `irq_n` goes low in the cycle after the edge that samples a qualifying result. A `clr_cmd` pulse returns it high one cycle later, and `ara_ok` has no effect.
- R6: With `mode` = 10 (alert), an `ara_ok` pulse clears the interrupt one cycle later, and `clr_cmd` has no effect. Mode 11 clears the same way.
- R7: With `mode` = 11, a `cfg_wr` pulse drives `irq_n` low in the next cycle, with no result needed.
- R8: Persistence code 000 makes every valid result raise the interrupt whatever its value. Code 001 makes any single out-of-window result raise it.
- R9: Persistence code 010 needs SHORT_RUNS consecutive out-of-window results, and codes 011 to 111 need LONG_RUNS. A valid in-window result restarts the run. The run count saturates and is not restarted by firing, so an out-of-window result after a clear fires again at once.
- R10: When a qualifying result and a clear are sampled on the same edge, the interrupt stays asserted.
- R11: With `stop_en` = 1, `integ_stop` is 1 in every cycle in which `irq_n` is low, and it stays latched. It falls only after an edge that samples `adc_en` = 0 while no interrupt is pending.
- R12: Outside mode 00, an asserted interrupt stays asserted over idle cycles until its clear arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | New conversion results present this cycle |
| res_bus | input | NUM_CH*DATA_W | All channel results; channel k at bits k*DATA_W and up |
| src_sel | input | $clog2(NUM_CH) | Channel compared against the window |
| thr_lo | input | DATA_W | Lower window bound (inclusive in-window) |
| thr_hi | input | DATA_W | Upper window bound (inclusive in-window) |
| mode | input | 2 | 00 off, 01 level, 10 alert, 11 forced then alert |
| persist | input | 3 | Persistence code |
| stop_en | input | 1 | Halt integration while interrupted |
| cfg_wr | input | 1 | Control register written this cycle |
| clr_cmd | input | 1 | Host clear command (level mode) |
| ara_ok | input | 1 | Alert-response cycle won (alert modes) |
| adc_en | input | 1 | Converter enable as programmed |
| irq_n | output | 1 | Interrupt, active low |
| integ_stop | output | 1 | Request to halt integration |

## Verification
The bench aims at threshold-equal results and at the wrong channel being out of window. A design that used inclusive comparisons, or that decoded the select wrongly, would interrupt where it must not. It also drives clears that arrive with the wrong mode and a clear on the same edge as a new qualifying result. A design with swapped clear paths or the wrong priority would drop the line early. Persistence runs stop one short of the limit, are broken by an in-window result and use codes above 011, which exposes off-by-one counters and a missing restart. The halt release is tried with the enable dropped both before and after the clear, which catches a latch that frees integration too early.

// File: rtl/win_irq_pkg.sv
package win_irq_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_LEVEL = 2'b01,
        MODE_ALERT = 2'b10,
        MODE_FORCE = 2'b11
    } irq_mode_e;

    typedef enum logic [1:0] {
        PER_ALWAYS,
        PER_ANY,
        PER_SHORT,
        PER_LONG
    } persist_e;

    // one compared sample as seen by the filter
    typedef struct packed {
        logic valid;
        logic outside;
    } sample_t;

    function automatic persist_e decode_persist(input logic [2:0] code);
        case (code)
            3'd0:    return PER_ALWAYS;
            3'd1:    return PER_ANY;
            3'd2:    return PER_SHORT;
            default: return PER_LONG;
        endcase
    endfunction

    function automatic logic is_alert(input irq_mode_e m);
        return (m == MODE_ALERT) || (m == MODE_FORCE);
    endfunction

endpackage

// File: rtl/win_irq_window.sv
module win_irq_window
    import win_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input  logic                     res_vld,
    input  logic [NUM_CH*DATA_W-1:0] res_bus,
    input  logic [SEL_W-1:0]         src_sel,
    input  logic [DATA_W-1:0]        thr_lo,
    input  logic [DATA_W-1:0]        thr_hi,
    output sample_t                  smp
);
    logic [DATA_W-1:0] chan [NUM_CH];
    logic [DATA_W-1:0] picked;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign chan[g] = res_bus[g*DATA_W +: DATA_W];
    end

    assign picked = chan[src_sel];

    always_comb begin
        smp.valid   = res_vld;
        smp.outside = (picked < thr_lo) || (picked > thr_hi);
    end
endmodule

// File: rtl/win_irq_persist.sv
module win_irq_persist
    import win_irq_pkg::*;
#(
    parameter int SHORT_RUNS = 4,
    parameter int LONG_RUNS  = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  sample_t    smp,
    input  logic [2:0] persist,
    output logic       qualify
);
    localparam int CNT_W = $clog2(LONG_RUNS + 1);
    localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_RUNS);
    localparam logic [CNT_W-1:0] LONG_N  = CNT_W'(LONG_RUNS);

    logic [CNT_W-1:0] run_q, run_d, need;
    persist_e         code;

    always_comb begin
        code  = decode_persist(persist);
        run_d = run_q;
        if (smp.valid) begin
            if (!smp.outside)
                run_d = '0;
            else if (run_q != LONG_N)
                run_d = run_q + 1'b1;
        end
        case (code)
            PER_ALWAYS: need = '0;
            PER_ANY:    need = CNT_W'(1);
            PER_SHORT:  need = SHORT_N;
            default:    need = LONG_N;
        endcase
        qualify = smp.valid &&
                  ((code == PER_ALWAYS) || (smp.outside && (run_d >= need)));
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end
endmodule

// File: rtl/win_irq_state.sv
module win_irq_state
    import win_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       qualify,
    input  logic       cfg_wr,
    input  logic       clr_cmd,
    input  logic       ara_ok,
    output logic       pend
);
    irq_mode_e m;
    logic      set_ev, clr_ev;

    always_comb begin
        m      = irq_mode_e'(mode);
        set_ev = qualify || (cfg_wr && (m == MODE_FORCE));
        clr_ev = ((m == MODE_LEVEL) && clr_cmd) || (is_alert(m) && ara_ok);
    end

    always_ff @(posedge clk) begin
        if (rst)                 pend <= 1'b0;
        else if (m == MODE_OFF)  pend <= 1'b0;
        else if (set_ev)         pend <= 1'b1;   // set wins over clear
        else if (clr_ev)         pend <= 1'b0;
    end
endmodule

// File: rtl/win_irq_halt.sv
module win_irq_halt (
    input  logic clk,
    input  logic rst,
    input  logic stop_en,
    input  logic adc_en,
    input  logic pend,
    output logic integ_stop
);
    logic halt_q;

    always_ff @(posedge clk) begin
        if (rst)                     halt_q <= 1'b0;
        else if (stop_en && pend)    halt_q <= 1'b1;
        else if (!adc_en && !pend)   halt_q <= 1'b0;
    end

    assign integ_stop = halt_q || (stop_en && pend);
endmodule

// File: rtl/win_irq_ctrl.sv
module win_irq_ctrl
    import win_irq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int NUM_CH     = 4,
    parameter int SHORT_RUNS = 4,
    parameter int LONG_RUNS  = 12,
    localparam int SEL_W     = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     res_vld,
    input  logic [NUM_CH*DATA_W-1:0] res_bus,
    input  logic [SEL_W-1:0]         src_sel,
    input  logic [DATA_W-1:0]        thr_lo,
    input  logic [DATA_W-1:0]        thr_hi,
    input  logic [1:0]               mode,
    input  logic [2:0]               persist,
    input  logic                     stop_en,
    input  logic                     cfg_wr,
    input  logic                     clr_cmd,
    input  logic                     ara_ok,
    input  logic                     adc_en,
    output logic                     irq_n,
    output logic                     integ_stop
);
    sample_t smp;
    logic    qualify;
    logic    pend;

    win_irq_window #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_window (
        .res_vld (res_vld),
        .res_bus (res_bus),
        .src_sel (src_sel),
        .thr_lo  (thr_lo),
        .thr_hi  (thr_hi),
        .smp     (smp)
    );

    win_irq_persist #(.SHORT_RUNS(SHORT_RUNS), .LONG_RUNS(LONG_RUNS)) u_persist (
        .clk     (clk),
        .rst     (rst),
        .smp     (smp),
        .persist (persist),
        .qualify (qualify)
    );

    win_irq_state u_state (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .qualify (qualify),
        .cfg_wr  (cfg_wr),
        .clr_cmd (clr_cmd),
        .ara_ok  (ara_ok),
        .pend    (pend)
    );

    win_irq_halt u_halt (
        .clk        (clk),
        .rst        (rst),
        .stop_en    (stop_en),
        .adc_en     (adc_en),
        .pend       (pend),
        .integ_stop (integ_stop)
    );

    assign irq_n = ~pend;
endmodule

// File: rtl/win_irq_checker.sv
module win_irq_checker #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4,
    localparam int SEL_W = $clog2(NUM_CH)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     res_vld,
    input logic [NUM_CH*DATA_W-1:0] res_bus,
    input logic [SEL_W-1:0]         src_sel,
    input logic [DATA_W-1:0]        thr_lo,
    input logic [DATA_W-1:0]        thr_hi,
    input logic [1:0]               mode,
    input logic [2:0]               persist,
    input logic                     stop_en,
    input logic                     cfg_wr,
    input logic                     clr_cmd,
    input logic                     ara_ok,
    input logic                     adc_en,
    input logic                     irq_n,
    input logic                     integ_stop
);
    logic [DATA_W-1:0] sel_val;
    logic              in_win;

    assign sel_val = res_bus[src_sel*DATA_W +: DATA_W];
    assign in_win  = (sel_val >= thr_lo) && (sel_val <= thr_hi);

    // R3
    in_window_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && in_win && irq_n && persist != 3'd0 && !cfg_wr) |=> irq_n);

    // R4
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00) |=> irq_n);

    // R5
    level_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && clr_cmd && !res_vld) |=> irq_n);

    // R6
    alert_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && ara_ok && !res_vld && !cfg_wr) |=> irq_n);

    // R7
    force_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && cfg_wr) |=> !irq_n);

    // R8
    every_result_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && res_vld && persist == 3'd0) |=> !irq_n);

    // R11
    stop_follows_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_en && !irq_n) |-> integ_stop);

    // R11
    stop_latched_chk: assert property (@(posedge clk) disable iff (rst)
        (integ_stop && adc_en) |=> integ_stop);

    // R12
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && mode != 2'b00 && !clr_cmd && !ara_ok) |=> !irq_n);
endmodule

bind win_irq_ctrl win_irq_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .res_vld    (res_vld),
    .res_bus    (res_bus),
    .src_sel    (src_sel),
    .thr_lo     (thr_lo),
    .thr_hi     (thr_hi),
    .mode       (mode),
    .persist    (persist),
    .stop_en    (stop_en),
    .cfg_wr     (cfg_wr),
    .clr_cmd    (clr_cmd),
    .ara_ok     (ara_ok),
    .adc_en     (adc_en),
    .irq_n      (irq_n),
    .integ_stop (integ_stop)
);

// File: tb/win_irq_ctrl_test.sv
`timescale 1ns/1ps
module win_irq_ctrl_test;
    localparam int DW  = 16;
    localparam int NCH = 4;
    localparam int SR  = 4;
    localparam int LR  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic res_vld = 1'b0;
    logic [NCH*DW-1:0] res_bus = '0;
    logic [1:0] src_sel = 2'd2;
    logic [DW-1:0] thr_lo = 16'd100;
    logic [DW-1:0] thr_hi = 16'd200;
    logic [1:0] mode = 2'b00;
    logic [2:0] persist = 3'd0;
    logic stop_en = 1'b0, cfg_wr = 1'b0, clr_cmd = 1'b0, ara_ok = 1'b0, adc_en = 1'b1;
    logic irq_n, integ_stop;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pend = 0, m_run = 0, m_halt = 0;

    always #2.5 clk = ~clk;

    win_irq_ctrl #(.DATA_W(DW), .NUM_CH(NCH), .SHORT_RUNS(SR), .LONG_RUNS(LR)) uut (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_bus(res_bus), .src_sel(src_sel),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .mode(mode), .persist(persist),
        .stop_en(stop_en), .cfg_wr(cfg_wr), .clr_cmd(clr_cmd), .ara_ok(ara_ok),
        .adc_en(adc_en), .irq_n(irq_n), .integ_stop(integ_stop));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: advances on every rising edge from the sampled inputs
    always @(posedge clk) begin
        if (rst) begin
            m_pend = 0; m_run = 0; m_halt = 0;
        end else begin
            int v, need, nrun;
            bit outside, setc, clrc;
            v = int'(res_bus[src_sel*DW +: DW]);
            outside = (v < int'(thr_lo)) || (v > int'(thr_hi));
            nrun = m_run;
            if (res_vld) nrun = outside ? ((m_run < LR) ? m_run + 1 : LR) : 0;
            need = (persist == 0) ? 0 : (persist == 1) ? 1 : (persist == 2) ? SR : LR;
            setc = (res_vld && (persist == 0 || (outside && nrun >= need))) ||
                   (cfg_wr && mode == 2'b11);
            clrc = (mode == 2'b01 && clr_cmd) || (mode[1] && ara_ok);
            if (stop_en && m_pend != 0) m_halt = 1;
            else if (!adc_en && m_pend == 0) m_halt = 0;
            if (mode == 2'b00) m_pend = 0;
            else if (setc) m_pend = 1;
            else if (clrc) m_pend = 0;
            m_run = nrun;
        end
    end

    // compare with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, "model irq_n", irq_n, logic'(m_pend == 0));
            chk(cur_req, "model integ_stop", integ_stop,
                logic'(m_halt != 0 || (stop_en && m_pend != 0)));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ch(input int k, input int v);
        res_bus[k*DW +: DW] = DW'(v);
    endtask

    task automatic send(input int v);
        set_ch(int'(src_sel), v);
        res_vld = 1'b1;
        tick();
        res_vld = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_cmd = 1'b1; tick(); clr_cmd = 1'b0;
    endtask

    task automatic pulse_ara();
        ara_ok = 1'b1; tick(); ara_ok = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) set_ch(k, 999);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1", "irq_n after reset", irq_n, 1'b1);
        chk("R1", "integ_stop after reset", integ_stop, 1'b0);

        // window edges; other channels sit out of window (R2, R3)
        cur_req = "R3";
        mode = 2'b01; persist = 3'd1;
        send(150); chk("R3", "inside", irq_n, 1'b1);
        send(200); chk("R3", "equal high", irq_n, 1'b1);
        send(100); chk("R3", "equal low", irq_n, 1'b1);
        chk("R2", "other channels ignored", irq_n, 1'b1);

        cur_req = "R5";
        send(201); chk("R5", "level set", irq_n, 1'b0);
        pulse_ara(); chk("R5", "ara ignored in level", irq_n, 1'b0);
        pulse_clr(); chk("R5", "level clear", irq_n, 1'b1);

        cur_req = "R2";
        src_sel = 2'd0; set_ch(2, 150);
        send(999); chk("R2", "channel 0 selected", irq_n, 1'b0);
        pulse_clr();
        src_sel = 2'd2;

        cur_req = "R10";
        set_ch(2, 50); res_vld = 1'b1; clr_cmd = 1'b1; tick();
        res_vld = 1'b0; clr_cmd = 1'b0;
        chk("R10", "set beats clear", irq_n, 1'b0);

        cur_req = "R12";
        repeat (5) tick();
        chk("R12", "held over idle", irq_n, 1'b0);

        cur_req = "R4";
        mode = 2'b00; tick(); chk("R4", "off mode high", irq_n, 1'b1);
        send(20); chk("R4", "off mode result", irq_n, 1'b1);
        mode = 2'b01; tick(); chk("R4", "nothing kept", irq_n, 1'b1);

        cur_req = "R8";
        persist = 3'd0;
        send(150); chk("R8", "code 000 in window fires", irq_n, 1'b0);
        pulse_clr();

        cur_req = "R9";
        persist = 3'd2;
        send(150);
        repeat (SR - 1) send(10);
        chk("R9", "short run one short", irq_n, 1'b1);
        send(150); chk("R9", "in window restarts", irq_n, 1'b1);
        repeat (SR - 1) send(10);
        chk("R9", "short run one short again", irq_n, 1'b1);
        send(10); chk("R9", "short run reached", irq_n, 1'b0);
        pulse_clr();
        send(10); chk("R9", "saturated run fires at once", irq_n, 1'b0);
        pulse_clr();

        persist = 3'd3;
        send(150);
        repeat (LR - 1) send(300);
        chk("R9", "long run one short", irq_n, 1'b1);
        send(300); chk("R9", "long run reached", irq_n, 1'b0);
        pulse_clr();

        persist = 3'd7;
        send(150);
        repeat (LR - 1) send(300);
        chk("R9", "code 111 one short", irq_n, 1'b1);
        send(300); chk("R9", "code 111 as long", irq_n, 1'b0);
        pulse_clr();

        cur_req = "R6";
        mode = 2'b10; persist = 3'd1;
        send(10); chk("R6", "alert set", irq_n, 1'b0);
        pulse_clr(); chk("R6", "clear cmd ignored", irq_n, 1'b0);
        pulse_ara(); chk("R6", "alert response clears", irq_n, 1'b1);

        cur_req = "R7";
        mode = 2'b11; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        chk("R7", "forced", irq_n, 1'b0);
        pulse_clr(); chk("R7", "clear cmd ignored in 11", irq_n, 1'b0);
        pulse_ara(); chk("R6", "ara clears mode 11", irq_n, 1'b1);

        cur_req = "R11";
        mode = 2'b01; persist = 3'd1; stop_en = 1'b1; adc_en = 1'b1;
        tick(); chk("R11", "no stop idle", integ_stop, 1'b0);
        send(10); chk("R11", "stop with irq", integ_stop, 1'b1);
        pulse_clr(); chk("R11", "stop latched after clear", integ_stop, 1'b1);
        adc_en = 1'b0; tick(); chk("R11", "released by enable low", integ_stop, 1'b0);
        adc_en = 1'b1; tick(); chk("R11", "stays free", integ_stop, 1'b0);
        send(10); adc_en = 1'b0; tick();
        chk("R11", "enable low, irq pending", integ_stop, 1'b1);
        pulse_clr(); chk("R11", "one cycle after clear", integ_stop, 1'b1);
        tick(); chk("R11", "released", integ_stop, 1'b0);
        adc_en = 1'b1; stop_en = 1'b0; tick();

        // mixed traffic against the model
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < NCH; k++) set_ch(k, 60 + int'($urandom % 180));
            res_vld = ($urandom % 3) != 0;
            src_sel = 2'($urandom % 4);
            if ($urandom % 40 == 0) mode = 2'($urandom % 4);
            if ($urandom % 40 == 0) persist = 3'($urandom % 8);
            cfg_wr  = ($urandom % 30) == 0;
            clr_cmd = ($urandom % 8) == 0;
            ara_ok  = ($urandom % 8) == 0;
            if ($urandom % 20 == 0) stop_en = ~stop_en;
            if ($urandom % 10 == 0) adc_en = ~adc_en;
            tick();
        end
        res_vld = 1'b0; cfg_wr = 1'b0; clr_cmd = 1'b0; ara_ok = 1'b0;
        tick();

        done = 1;
        summary();
        $finish;
    end
endmodule